// File: doc/BRIEF.md
# Dual-Channel Interrupt Priority Vectoring

This block sits between the two channels of a serial controller and the CPU's interrupt line. Each channel raises four kinds of event: a received character, a special receive condition (an error or end of frame), a transmit buffer becoming empty, and an external/status change. Every event sets its own pending latch. That latch stays set until the channel logic pulses the matching clear strobe. Three software enables per channel gate receive, transmit and external/status interrupts. The special receive condition is gated by the receive enable. A single interrupt output is high while any enabled source is pending.

When the CPU acknowledges, the block captures an 8-bit vector. If the vector-modify control is clear in both channels, the vector is the programmed base. If the control is set in either channel, bits 3 to 1 of the base are replaced by a code for the highest-priority enabled pending source. There are eight codes, so the CPU can branch straight to one of eight service routines. Channel A always wins over channel B. Within a channel the order is special receive, then received character, then transmit, then external/status.

Top module: `irq_prio_vector`

## Requirements
- R1: A request pulse sets the pending latch of its source on the next clock edge. The latch stays set, acknowledges included, until that source's own clear strobe. When a request and the clear for the same source arrive together, the request wins.
- R2: `irq_o` is high exactly when at least one source is pending with its enable high, visible one cycle after the request pulse. A special receive condition is gated by the receive enable of its channel.
- R3: With all receive, transmit and external/status enables low, `irq_o` stays low whatever is pending (polled operation).
- R4: A transmit-empty pulse sets the transmit pending latch only if a transmit load has occurred in that channel since the previous transmit interrupt was raised. Otherwise it has no effect.
- R5: Priority is channel A (index 0 of every per-channel port) over channel B (index 1). Within one channel the order is special receive, receive, transmit, external/status.
- R6: With modification active, the vector is {base[7:4], code, base[0]}. The codes are: A special 111, A receive 110, A external 101, A transmit 100, B special 011, B receive 010, B external 001, B transmit 000.
- R7: A vector-modify bit set in either channel enables modification for requests from both channels.
- R8: With both vector-modify bits low, the acknowledged vector equals the base unchanged.
- R9: `vec_o` is captured at the clock edge that ends an acknowledge cycle. It uses the pending state from before that edge, so a request arriving in the acknowledge cycle does not alter it. It then holds until the next acknowledge. After reset `vec_o` is 0 and nothing is pending.
- R10: An acknowledge with no enabled pending source returns the base unchanged, even with modification active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req_i | input | 2 | Received-character pulse per channel |
| spc_req_i | input | 2 | Special receive condition pulse per channel |
| tx_empty_i | input | 2 | Transmit buffer became empty, per channel |
| tx_load_i | input | 2 | Character written to transmit buffer, per channel |
| ext_req_i | input | 2 | External/status change pulse per channel |
| rx_clr_i | input | 2 | Clear receive pending |
| spc_clr_i | input | 2 | Clear special receive pending |
| tx_clr_i | input | 2 | Clear transmit pending |
| ext_clr_i | input | 2 | Clear external/status pending |
| rx_en_i | input | 2 | Receive interrupt enable |
| tx_en_i | input | 2 | Transmit interrupt enable |
| ext_en_i | input | 2 | External/status interrupt enable |
| modvec_i | input | 2 | Vector-modify control per channel |
| base_vec_i | input | 8 | Programmed base vector |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 8 | Acknowledged vector |

## Verification
The assertions assume that `ack_i` is a single-cycle strobe and that enables, vector-modify bits and the base are held steady across the acknowledge cycle, so the captured vector can be compared with the values sampled one cycle earlier. The bench changes configuration only on falling edges between acknowledges. It raises requests in a cycle separate from the acknowledge, except in the one case written to test that a late request is ignored. The pending-hold property assumes clears come only as explicit strobes. The bench raises them only when it starts a new pattern or clears one source on purpose.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NCH   = 2;
    localparam int NKIND = 4;
    localparam int VW    = 8;
    localparam int CW    = 3;
    localparam int PW    = NCH * NKIND;

    // kind part of the 3-bit code; bit 2 marks channel A
    localparam logic [1:0] KC_SPC = 2'b11;
    localparam logic [1:0] KC_RX  = 2'b10;
    localparam logic [1:0] KC_EXT = 2'b01;
    localparam logic [1:0] KC_TX  = 2'b00;

    typedef struct packed {
        logic spc;
        logic rx;
        logic tx;
        logic ext;
    } pend_t;

    typedef struct packed {
        pend_t pend;
        logic  armed;
    } chan_st_t;

    typedef struct packed {
        logic [VW-1:0] vec;
    } vec_st_t;
endpackage

// File: rtl/irqv_chan.sv
module irqv_chan
    import irqv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_req_i,
    input  logic  spc_req_i,
    input  logic  tx_empty_i,
    input  logic  tx_load_i,
    input  logic  ext_req_i,
    input  logic  rx_clr_i,
    input  logic  spc_clr_i,
    input  logic  tx_clr_i,
    input  logic  ext_clr_i,
    output pend_t pend_o
);
    chan_st_t st_d, st_q;
    logic     tx_fire;

    always_comb begin
        st_d     = st_q;
        tx_fire  = tx_empty_i && st_q.armed;
        // a request wins over a clear in the same cycle
        st_d.pend.rx  = rx_req_i  | (st_q.pend.rx  & ~rx_clr_i);
        st_d.pend.spc = spc_req_i | (st_q.pend.spc & ~spc_clr_i);
        st_d.pend.ext = ext_req_i | (st_q.pend.ext & ~ext_clr_i);
        st_d.pend.tx  = tx_fire   | (st_q.pend.tx  & ~tx_clr_i);
        // a load arms the transmitter; an accepted empty event disarms it
        st_d.armed    = tx_load_i | (st_q.armed & ~tx_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  pend_t [NCH-1:0] pend_i,
    input  logic  [NCH-1:0] rx_en_i,
    input  logic  [NCH-1:0] tx_en_i,
    input  logic  [NCH-1:0] ext_en_i,
    output logic            any_o,
    output logic  [CW-1:0]  code_o
);
    // walk from lowest to highest priority; the last hit wins
    always_comb begin
        any_o  = 1'b0;
        code_o = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pend_i[c].ext && ext_en_i[c]) begin
                any_o  = 1'b1;
                code_o = {1'(c == 0), KC_EXT};
            end
            if (pend_i[c].tx && tx_en_i[c]) begin
                any_o  = 1'b1;
                code_o = {1'(c == 0), KC_TX};
            end
            if (pend_i[c].rx && rx_en_i[c]) begin
                any_o  = 1'b1;
                code_o = {1'(c == 0), KC_RX};
            end
            if (pend_i[c].spc && rx_en_i[c]) begin
                any_o  = 1'b1;
                code_o = {1'(c == 0), KC_SPC};
            end
        end
    end
endmodule

// File: rtl/irqv_vec.sv
module irqv_vec
    import irqv_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic          modify_i,
    input  logic          any_i,
    input  logic [CW-1:0] code_i,
    input  logic [VW-1:0] base_i,
    output logic [VW-1:0] vec_o
);
    vec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i) begin
            if (modify_i && any_i)
                st_d.vec = {base_i[VW-1:CW+1], code_i, base_i[0]};
            else
                st_d.vec = base_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_o = st_q.vec;
endmodule

// File: rtl/irq_prio_vector.sv
module irq_prio_vector
    import irqv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  rx_req_i,
    input  logic [NCH-1:0]  spc_req_i,
    input  logic [NCH-1:0]  tx_empty_i,
    input  logic [NCH-1:0]  tx_load_i,
    input  logic [NCH-1:0]  ext_req_i,
    input  logic [NCH-1:0]  rx_clr_i,
    input  logic [NCH-1:0]  spc_clr_i,
    input  logic [NCH-1:0]  tx_clr_i,
    input  logic [NCH-1:0]  ext_clr_i,
    input  logic [NCH-1:0]  rx_en_i,
    input  logic [NCH-1:0]  tx_en_i,
    input  logic [NCH-1:0]  ext_en_i,
    input  logic [NCH-1:0]  modvec_i,
    input  logic [VW-1:0]   base_vec_i,
    input  logic            ack_i,
    output logic            irq_o,
    output logic [VW-1:0]   vec_o
);
    pend_t [NCH-1:0] pend;
    logic  [PW-1:0]  pend_flat;
    logic            any_hit;
    logic  [CW-1:0]  code;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irqv_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_req_i   (rx_req_i[c]),
            .spc_req_i  (spc_req_i[c]),
            .tx_empty_i (tx_empty_i[c]),
            .tx_load_i  (tx_load_i[c]),
            .ext_req_i  (ext_req_i[c]),
            .rx_clr_i   (rx_clr_i[c]),
            .spc_clr_i  (spc_clr_i[c]),
            .tx_clr_i   (tx_clr_i[c]),
            .ext_clr_i  (ext_clr_i[c]),
            .pend_o     (pend[c])
        );
        assign pend_flat[c*NKIND +: NKIND] = pend[c];
    end

    irqv_prio u_prio (
        .pend_i   (pend),
        .rx_en_i  (rx_en_i),
        .tx_en_i  (tx_en_i),
        .ext_en_i (ext_en_i),
        .any_o    (any_hit),
        .code_o   (code)
    );

    irqv_vec u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ack_i),
        .modify_i (|modvec_i),
        .any_i    (any_hit),
        .code_i   (code),
        .base_i   (base_vec_i),
        .vec_o    (vec_o)
    );

    assign irq_o = any_hit;
endmodule

// File: rtl/irq_prio_vector_chk.sv
module irq_prio_vector_chk
    import irqv_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] rx_clr_i,
    input logic [NCH-1:0] spc_clr_i,
    input logic [NCH-1:0] tx_clr_i,
    input logic [NCH-1:0] ext_clr_i,
    input logic [NCH-1:0] rx_en_i,
    input logic [NCH-1:0] tx_en_i,
    input logic [NCH-1:0] ext_en_i,
    input logic [NCH-1:0] modvec_i,
    input logic [VW-1:0]  base_vec_i,
    input logic           ack_i,
    input logic           irq_o,
    input logic [VW-1:0]  vec_o,
    input logic [PW-1:0]  pend_flat
);
    logic [PW-1:0] keep_mask;
    logic          a_live;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            keep_mask[c*NKIND + 3] = ~spc_clr_i[c];
            keep_mask[c*NKIND + 2] = ~rx_clr_i[c];
            keep_mask[c*NKIND + 1] = ~tx_clr_i[c];
            keep_mask[c*NKIND + 0] = ~ext_clr_i[c];
        end
        a_live = ((pend_flat[3] | pend_flat[2]) & rx_en_i[0])
               | (pend_flat[1] & tx_en_i[0])
               | (pend_flat[0] & ext_en_i[0]);
    end

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_flat & $past(pend_flat & keep_mask)) == $past(pend_flat & keep_mask))); // R1
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_flat != '0)); // R2
    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ({rx_en_i, tx_en_i, ext_en_i} == '0) |-> !irq_o); // R3
    AST_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (|modvec_i) && a_live) |=> vec_o[3]); // R5
    AST_BASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (vec_o[7:4] == $past(base_vec_i[7:4])) && (vec_o[0] == $past(base_vec_i[0]))); // R6
    AST_PLAIN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (modvec_i == '0)) |=> (vec_o == $past(base_vec_i))); // R8
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(vec_o)); // R9
endmodule

bind irq_prio_vector irq_prio_vector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_clr_i   (rx_clr_i),
    .spc_clr_i  (spc_clr_i),
    .tx_clr_i   (tx_clr_i),
    .ext_clr_i  (ext_clr_i),
    .rx_en_i    (rx_en_i),
    .tx_en_i    (tx_en_i),
    .ext_en_i   (ext_en_i),
    .modvec_i   (modvec_i),
    .base_vec_i (base_vec_i),
    .ack_i      (ack_i),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .pend_flat  (pend_flat)
);

// File: tb/irq_prio_vector_tb.sv
module irq_prio_vector_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rx_req, spc_req, tx_empty, tx_load, ext_req;
    logic [1:0] rx_clr, spc_clr, tx_clr, ext_clr;
    logic [1:0] rx_en, tx_en, ext_en, modvec;
    logic [7:0] base;
    logic       ack;
    logic       irq;
    logic [7:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_prio_vector u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_req_i(rx_req), .spc_req_i(spc_req), .tx_empty_i(tx_empty),
        .tx_load_i(tx_load), .ext_req_i(ext_req),
        .rx_clr_i(rx_clr), .spc_clr_i(spc_clr), .tx_clr_i(tx_clr), .ext_clr_i(ext_clr),
        .rx_en_i(rx_en), .tx_en_i(tx_en), .ext_en_i(ext_en), .modvec_i(modvec),
        .base_vec_i(base), .ack_i(ack), .irq_o(irq), .vec_o(vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pattern bits: [7:4] channel A {spc,rx,tx,ext}, [3:0] channel B
    function automatic logic [3:0] live(input logic [7:0] p, input logic [1:0] er,
                                        input logic [1:0] et, input logic [1:0] ee);
        logic [3:0] r;
        // r: {found, code[2:0]}
        r = 4'b0;
        for (int c = 0; c < 2; c++) begin
            int sh = (c == 0) ? 4 : 0;
            if (r[3] == 1'b0) begin
                if (p[sh+3] && er[c])      r = {1'b1, 1'(c == 0), 2'd3};
                else if (p[sh+2] && er[c]) r = {1'b1, 1'(c == 0), 2'd2};
                else if (p[sh+1] && et[c]) r = {1'b1, 1'(c == 0), 2'd0};
                else if (p[sh+0] && ee[c]) r = {1'b1, 1'(c == 0), 2'd1};
            end
        end
        return r;
    endfunction

    task automatic idle_inputs();
        rx_req = '0; spc_req = '0; tx_empty = '0; tx_load = '0; ext_req = '0;
        rx_clr = '0; spc_clr = '0; tx_clr = '0; ext_clr = '0;
        ack = 1'b0;
    endtask

    task automatic load_pattern(input logic [7:0] p);
        @(negedge clk);
        idle_inputs();
        rx_clr = '1; spc_clr = '1; tx_clr = '1; ext_clr = '1;
        tx_load = {p[1], p[5]};
        @(negedge clk);
        idle_inputs();
        spc_req  = {p[3], p[7]};
        rx_req   = {p[2], p[6]};
        tx_empty = {p[1], p[5]};
        ext_req  = {p[0], p[4]};
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic ack_and_check(input logic [7:0] p, input string req);
        logic [3:0] r;
        logic [7:0] e;
        r = live(p, rx_en, tx_en, ext_en);
        chk(irq == r[3], "R2", irq, r[3]);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        if ((modvec != 2'b00) && r[3]) e = {base[7:4], r[2:0], base[0]};
        else                           e = base;
        chk(vec == e, req, vec, e);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        rx_en = '1; tx_en = '1; ext_en = '1; modvec = '0; base = 8'h00;
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R9 reset irq", irq, 0);
        chk(vec == 8'h00, "R9 reset vec", vec, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R7 R8 R10: every pattern under three vector-modify settings
        for (int m = 0; m < 3; m++) begin
            modvec = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
            for (int p = 0; p < 256; p++) begin
                base = 8'(p * 37 + m * 11 + 5);
                load_pattern(8'(p));
                ack_and_check(8'(p), (m == 0) ? "R8" : "R5/R6/R7/R10");
            end
        end

        // R2 R3 R5: enable sweep over three pending patterns
        modvec = 2'b11;
        for (int e = 0; e < 64; e++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] p;
                p = (k == 0) ? 8'hFF : (k == 1) ? 8'h5A : 8'h33;
                rx_en = e[1:0]; tx_en = e[3:2]; ext_en = e[5:4];
                base = 8'(e * 13 + k);
                load_pattern(p);
                if (e == 0) chk(irq == 1'b0, "R3 polled", irq, 0);
                ack_and_check(p, "R2/R5");
            end
        end
        rx_en = '1; tx_en = '1; ext_en = '1;

        // R4: transmit empty without a prior load is ignored
        load_pattern(8'h00);
        tx_empty = 2'b01;
        @(negedge clk);
        tx_empty = 2'b00;
        @(negedge clk);
        chk(irq == 1'b0, "R4 empty w/o load", irq, 0);
        tx_load = 2'b01;
        @(negedge clk);
        tx_load = 2'b00;
        tx_empty = 2'b01;
        @(negedge clk);
        tx_empty = 2'b00;
        @(negedge clk);
        chk(irq == 1'b1, "R4 empty after load", irq, 1);
        tx_clr = 2'b01;
        @(negedge clk);
        tx_clr = 2'b00;
        tx_empty = 2'b01;
        @(negedge clk);
        tx_empty = 2'b00;
        @(negedge clk);
        chk(irq == 1'b0, "R4 second empty", irq, 0);

        // R9 and R1: request during acknowledge, hold across acknowledge
        modvec = 2'b10; base = 8'hA0;
        load_pattern(8'h01);
        ack = 1'b1; spc_req = 2'b01;
        @(negedge clk);
        ack = 1'b0; spc_req = 2'b00;
        chk(vec == 8'hA2, "R9 late request", vec, 8'hA2);
        @(negedge clk);
        chk(vec == 8'hA2, "R9 hold", vec, 8'hA2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(vec == 8'hAE, "R1 pending kept", vec, 8'hAE);
        spc_clr = 2'b01;
        @(negedge clk);
        spc_clr = 2'b00;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(vec == 8'hA2, "R1 own clear", vec, 8'hA2);
        chk(irq == 1'b1, "R1 other kept", irq, 1);
        // request and clear together: request wins
        rx_req = 2'b10; rx_clr = 2'b10;
        @(negedge clk);
        idle_inputs();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(vec == 8'hA4, "R1 set over clear", vec, 8'hA4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule